// File: doc/BRIEF.md
# Paged Address Translation Unit

This block translates logical addresses on a 26-bit bus into physical addresses using a table of page entries, one entry per physical page. Each entry records which logical page currently lives in that physical page and a two-bit protection level. Logical addresses occupy the lower half of the bus, below 0x2000000. Physical RAM is reached in the region that starts at 0x2000000. Software loads an entry by writing to any address in the window that starts at 0x3800000. The written data is not used: the physical page, the logical page and the protection level are all taken from the bits of the address. Where those fields sit in the address depends on the page size in force.

Each request is accepted while `req_ready` is high. The unit then looks the logical page up in every valid entry in parallel and applies the protection check for the current processor mode. It returns either a physical address or an abort in a single-cycle response. A 2-bit control input selects a page size of 4, 8, 16 or 32 KB. A processor-mode input and an OS-enable control bit choose between supervisor, OS and user permission.

The controller walks four named states. IDLE waits for a request. IDLE→CHECK happens on acceptance. CHECK classifies the request and performs the lookup. CHECK→WRITE is taken for a supervisor write into the load window. CHECK→RESP is taken for every other request. WRITE stores the decoded entry, and WRITE→RESP follows unconditionally. RESP is the cycle in which the response pulse is visible, and RESP→IDLE follows unconditionally.

Top module: `page_xlate`

## Requirements
- R1: Reset clears the valid flag of every entry, so any lookup after reset aborts; out of reset `req_ready` is 1 and `resp_valid` is 0.
- R2: `resp_valid` is high for exactly one cycle. It rises at the second clock edge after acceptance for a lookup or a refused request, and at the third edge for an entry load. `req_ready` is low from acceptance until the cycle after the response.
- R3: With page size code 00 (4 KB), a load takes the physical page from address bits 6:0. Logical page bits 10:0 come from address bits 22:12, and logical page bits 12:11 come from address bits 11:10.
- R4: With code 01 (8 KB), physical page bit 6 is address bit 0 and physical page bits 5:0 are address bits 6:1. Logical page bits 9:0 are address bits 22:13, and logical page bits 11:10 are address bits 11:10.
- R5: With code 10 (16 KB), physical page bits 6:5 are address bits 1:0 and physical page bits 4:0 are address bits 6:2. Logical page bits 8:0 are address bits 22:14, and logical page bits 10:9 are address bits 11:10.
- R6: With code 11 (32 KB), physical page bit 6 is address bit 1, bit 5 is address bit 2 and bit 4 is address bit 0. Physical page bits 3:0 are address bits 6:3. Logical page bits 7:0 are address bits 22:15, and logical page bits 9:8 are address bits 11:10.
- R7: The logical page of a lookup is logical address bits 24:(12+s), where s is the size code. A granted lookup returns 0x2000000 + (physical page << (12+s)) + (address mod 2^(12+s)). Load responses return the window address with no abort. In every size, address bits 9:8 of a load give the protection level.
- R8: When several valid entries hold the requested logical page, the entry with the lowest physical page number is used.
- R9: With `cpu_sup` = 1 the mode is supervisor, whatever `ctl_os_en` holds, and reads and writes are allowed at all four levels.
- R10: With `cpu_sup` = 0 and `ctl_os_en` = 1 the mode is OS. Reads and writes are allowed at levels 0 and 1; only reads are allowed at levels 2 and 3.
- R11: With both inputs at 0 the mode is user. Level 0 allows reads and writes, level 1 allows only reads, and levels 2 and 3 allow nothing.
- R12: The response aborts, with `resp_paddr` = 0, in each of these cases: a lookup that matches no entry, a lookup that breaks the protection rule, a load-window write outside supervisor mode (which leaves the table unchanged), and any read or other access at or above 0x2000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_page_size | input | 2 | Page size code: 0=4 KB, 1=8 KB, 2=16 KB, 3=32 KB |
| ctl_os_en | input | 1 | Selects OS permission when not in supervisor mode |
| cpu_sup | input | 1 | Processor is in supervisor mode |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request (IDLE) |
| req_write | input | 1 | Request is a write |
| req_addr | input | 26 | Request address |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_abort | output | 1 | Request refused |
| resp_paddr | output | 26 | Physical address, or load-window address for a load |

## Verification
Every page size is swept over all 128 physical pages. Each page gets its own logical page and its own in-page offset, so a swapped or shifted field in any load layout shows up as a miss or a wrong physical address. A grid of protection level × mode × direction checks each cell of the permission matrix, and the case of supervisor and OS-enable both set shows whether supervisor takes precedence. A shared logical page loaded into pages 50, 70 and then 20 tells a lowest-index winner apart from a latest-write or highest-index winner. A refused user load followed by a lookup of the old mapping shows that a refused write leaves no trace in the table.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int PXU_ADDR_W     = 26;
    localparam int PXU_PPN_W      = 7;
    localparam int PXU_ENTRIES    = 1 << PXU_PPN_W;
    localparam int PXU_MIN_SHIFT  = 12;
    localparam int PXU_LPN_W      = PXU_ADDR_W - 1 - PXU_MIN_SHIFT;
    localparam int PXU_PPL_W      = 2;
    localparam logic [2:0] PXU_WINDOW_TAG = 3'b111;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_8K  = 2'd1,
        PG_16K = 2'd2,
        PG_32K = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        MODE_SVC  = 2'd0,
        MODE_OS   = 2'd1,
        MODE_USER = 2'd2
    } cpu_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } xl_state_e;

endpackage

// File: rtl/pxu_entry_decode.sv
module pxu_entry_decode
    import pxu_pkg::*;
(
    input  pg_size_e               pg,
    input  logic [22:0]            addr,
    output logic [PXU_PPN_W-1:0]   ppn,
    output logic [PXU_LPN_W-1:0]   lpn,
    output logic [PXU_PPL_W-1:0]   ppl
);

    logic unused_bit7;
    assign unused_bit7 = addr[7];

    assign ppl = addr[9:8];

    always_comb begin
        ppn = '0;
        lpn = '0;
        unique case (pg)
            PG_4K: begin
                ppn = addr[6:0];
                lpn = {addr[11:10], addr[22:12]};
            end
            PG_8K: begin
                ppn = {addr[0], addr[6:1]};
                lpn = {1'b0, addr[11:10], addr[22:13]};
            end
            PG_16K: begin
                ppn = {addr[1:0], addr[6:2]};
                lpn = {2'b00, addr[11:10], addr[22:14]};
            end
            PG_32K: begin
                ppn = {addr[1], addr[2], addr[0], addr[6:3]};
                lpn = {3'b000, addr[11:10], addr[22:15]};
            end
            default: begin
                ppn = '0;
                lpn = '0;
            end
        endcase
    end

endmodule

// File: rtl/pxu_table.sv
module pxu_table #(
    parameter int DEPTH = 128,
    parameter int LPN_W = 13,
    parameter int PPL_W = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LPN_W-1:0] wr_lpn,
    input  logic [PPL_W-1:0] wr_ppl,
    input  logic [LPN_W-1:0] look_lpn,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [PPL_W-1:0] hit_ppl
);

    logic [DEPTH-1:0] valid_q;
    logic [LPN_W-1:0] lpn_q [DEPTH];
    logic [PPL_W-1:0] ppl_q [DEPTH];
    logic [DEPTH-1:0] match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            lpn_q[wr_idx] <= wr_lpn;
            ppl_q[wr_idx] <= wr_ppl;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (lpn_q[g] == look_lpn);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit_ppl = ppl_q[hit_idx];

endmodule

// File: rtl/pxu_perm.sv
module pxu_perm
    import pxu_pkg::*;
(
    input  cpu_mode_e            mode,
    input  logic [PXU_PPL_W-1:0] ppl,
    input  logic                 is_write,
    output logic                 allow
);

    logic rd_ok;
    logic wr_ok;

    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        case (mode)
            MODE_SVC: begin
                rd_ok = 1'b1;
                wr_ok = 1'b1;
            end
            MODE_OS: begin
                rd_ok = 1'b1;
                wr_ok = !ppl[1];
            end
            MODE_USER: begin
                rd_ok = !ppl[1];
                wr_ok = (ppl == 2'b00);
            end
            default: begin
                rd_ok = 1'b0;
                wr_ok = 1'b0;
            end
        endcase
    end

    assign allow = is_write ? wr_ok : rd_ok;

endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import pxu_pkg::*;
#(
    parameter int N_PAGES = PXU_ENTRIES,
    localparam int AW     = PXU_ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ctl_page_size,
    input  logic          ctl_os_en,
    input  logic          cpu_sup,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    output logic          resp_valid,
    output logic          resp_abort,
    output logic [AW-1:0] resp_paddr
);

    xl_state_e state, state_nx;

    logic [AW-1:0] rq_addr;
    logic          rq_write;
    cpu_mode_e     rq_mode;
    pg_size_e      rq_pg;

    logic [PXU_PPN_W-1:0] ld_ppn;
    logic [PXU_LPN_W-1:0] ld_lpn;
    logic [PXU_PPL_W-1:0] ld_ppl;

    logic [PXU_LPN_W-1:0] look_lpn;
    logic                 tbl_hit;
    logic [PXU_PPN_W-1:0] tbl_idx;
    logic [PXU_PPL_W-1:0] tbl_ppl;
    logic                 perm_ok;

    logic          in_window;
    logic          is_logical;
    logic          do_load;
    logic          grant;
    logic [AW-1:0] phys_addr;

    // request capture on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_addr  <= '0;
            rq_write <= 1'b0;
            rq_mode  <= MODE_USER;
            rq_pg    <= PG_4K;
        end else if (state == ST_IDLE && req_valid) begin
            rq_addr  <= req_addr;
            rq_write <= req_write;
            rq_pg    <= pg_size_e'(ctl_page_size);
            if (cpu_sup) begin
                rq_mode <= MODE_SVC;
            end else if (ctl_os_en) begin
                rq_mode <= MODE_OS;
            end else begin
                rq_mode <= MODE_USER;
            end
        end
    end

    assign in_window  = (rq_addr[AW-1 -: 3] == PXU_WINDOW_TAG);
    assign is_logical = !rq_addr[AW-1];
    assign do_load    = in_window && rq_write && (rq_mode == MODE_SVC);

    pxu_entry_decode u_dec (
        .pg   (rq_pg),
        .addr (rq_addr[22:0]),
        .ppn  (ld_ppn),
        .lpn  (ld_lpn),
        .ppl  (ld_ppl)
    );

    always_comb begin
        look_lpn = '0;
        unique case (rq_pg)
            PG_4K:   look_lpn = rq_addr[24:12];
            PG_8K:   look_lpn = {1'b0, rq_addr[24:13]};
            PG_16K:  look_lpn = {2'b00, rq_addr[24:14]};
            PG_32K:  look_lpn = {3'b000, rq_addr[24:15]};
            default: look_lpn = '0;
        endcase
    end

    pxu_table #(
        .DEPTH (N_PAGES),
        .LPN_W (PXU_LPN_W),
        .PPL_W (PXU_PPL_W)
    ) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (state == ST_WRITE),
        .wr_idx   (ld_ppn),
        .wr_lpn   (ld_lpn),
        .wr_ppl   (ld_ppl),
        .look_lpn (look_lpn),
        .hit      (tbl_hit),
        .hit_idx  (tbl_idx),
        .hit_ppl  (tbl_ppl)
    );

    pxu_perm u_perm (
        .mode     (rq_mode),
        .ppl      (tbl_ppl),
        .is_write (rq_write),
        .allow    (perm_ok)
    );

    always_comb begin
        phys_addr = '0;
        unique case (rq_pg)
            PG_4K:   phys_addr = {1'b1, 6'b0, tbl_idx, rq_addr[11:0]};
            PG_8K:   phys_addr = {1'b1, 5'b0, tbl_idx, rq_addr[12:0]};
            PG_16K:  phys_addr = {1'b1, 4'b0, tbl_idx, rq_addr[13:0]};
            PG_32K:  phys_addr = {1'b1, 3'b0, tbl_idx, rq_addr[14:0]};
            default: phys_addr = '0;
        endcase
    end

    assign grant = is_logical && tbl_hit && perm_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_CHECK;
            ST_CHECK: state_nx = do_load ? ST_WRITE : ST_RESP;
            ST_WRITE: state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_abort <= 1'b0;
            resp_paddr <= '0;
        end else begin
            resp_valid <= 1'b0;
            resp_abort <= 1'b0;
            resp_paddr <= '0;
            unique case (state)
                ST_CHECK: begin
                    if (!do_load) begin
                        resp_valid <= 1'b1;
                        resp_abort <= !grant;
                        resp_paddr <= grant ? phys_addr : '0;
                    end
                end
                ST_WRITE: begin
                    resp_valid <= 1'b1;
                    resp_paddr <= rq_addr;
                end
                default: begin
                end
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);

endmodule

// File: rtl/pxu_checker.sv
module pxu_checker #(
    parameter int AW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          resp_valid,
    input logic          resp_abort,
    input logic [AW-1:0] resp_paddr
);

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid) else $error("response longer than one cycle"); // R2

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready) else $error("ready after accept"); // R2

    AST_BUSY_DURING_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready) else $error("ready during response"); // R2

    AST_ABORT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        resp_abort |-> (resp_valid && resp_paddr == '0)) else $error("stray abort"); // R12

    AST_GRANT_IN_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_abort) |-> resp_paddr[AW-1]) else $error("grant outside physical region"); // R7

endmodule

bind page_xlate pxu_checker #(.AW(26)) u_pxu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_abort (resp_abort),
    .resp_paddr (resp_paddr)
);

// File: tb/page_xlate_test.sv
`timescale 1ns/1ps
module page_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ctl_page_size = 2'd0;
    logic        ctl_os_en = 1'b0;
    logic        cpu_sup = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [25:0] req_addr = '0;
    logic        resp_valid;
    logic        resp_abort;
    logic [25:0] resp_paddr;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    page_xlate uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_page_size (ctl_page_size),
        .ctl_os_en     (ctl_os_en),
        .cpu_sup       (cpu_sup),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .resp_valid    (resp_valid),
        .resp_abort    (resp_abort),
        .resp_paddr    (resp_paddr)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [25:0] enc_load(input int s, input int ppn, input int lpn, input int ppl);
        int a;
        a = 32'h3800000 | ((ppl & 3) << 8);
        case (s)
            0: a = a | (ppn & 127) | ((lpn & 2047) << 12) | (((lpn >> 11) & 3) << 10);
            1: a = a | ((ppn >> 6) & 1) | ((ppn & 63) << 1)
                     | ((lpn & 1023) << 13) | (((lpn >> 10) & 3) << 10);
            2: a = a | ((ppn >> 5) & 3) | ((ppn & 31) << 2)
                     | ((lpn & 511) << 14) | (((lpn >> 9) & 3) << 10);
            default: a = a | (((ppn >> 6) & 1) << 1) | (((ppn >> 5) & 1) << 2)
                     | ((ppn >> 4) & 1) | ((ppn & 15) << 3)
                     | ((lpn & 255) << 15) | (((lpn >> 8) & 3) << 10);
        endcase
        return a[25:0];
    endfunction

    function automatic int lpn_of(input int s, input int ppn);
        return (ppn * 37 + 5) & ((1 << (13 - s)) - 1);
    endfunction

    function automatic int off_of(input int s, input int ppn);
        return (ppn * 97 + 13) & ((1 << (12 + s)) - 1);
    endfunction

    task automatic do_req(input string req, input bit wr, input logic [25:0] addr,
                          input int exp_lat, output bit ab, output logic [25:0] pa);
        int lat;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        chk(req, "R2 response latency", lat, exp_lat);
        ab = resp_abort;
        pa = resp_paddr;
        @(negedge clk);
        chk(req, "R2 pulse width", resp_valid, 0);
    endtask

    task automatic set_mode(input int m);
        @(negedge clk);
        cpu_sup   = (m == 0);
        ctl_os_en = (m == 1);
    endtask

    task automatic load(input string req, input int s, input int ppn, input int lpn, input int ppl);
        bit ab;
        logic [25:0] pa;
        logic [25:0] a;
        a = enc_load(s, ppn, lpn, ppl);
        do_req(req, 1'b1, a, 3, ab, pa);
        chk(req, "load abort", ab, 0);
        chk(req, "load echo address", pa, a);
    endtask

    task automatic lookup(input string req, input int s, input int lpn, input int off, input bit wr,
                          input int exp_ppn, input bit exp_abort);
        bit ab;
        logic [25:0] pa;
        logic [25:0] a;
        int exp_pa;
        a = 26'((lpn << (12 + s)) | off);
        do_req(req, wr, a, 2, ab, pa);
        exp_pa = exp_abort ? 0 : (32'h2000000 + (exp_ppn << (12 + s)) + off);
        chk(req, "abort", ab, exp_abort);
        chk(req, "physical address", pa, exp_pa);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual=hung expected=completion");
        finish_run();
    end

    initial begin
        bit ab;
        logic [25:0] pa;
        string tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", req_ready, 1);
        chk("R1", "resp_valid after reset", resp_valid, 0);
        lookup("R1", 0, 0, 0, 1'b0, 0, 1'b1);

        // full sweep of every page size over all physical pages
        for (int s = 0; s < 4; s++) begin
            tag = (s == 0) ? "R3" : (s == 1) ? "R4" : (s == 2) ? "R5" : "R6";
            @(negedge clk);
            ctl_page_size = 2'(s);
            set_mode(0);
            for (int p = 0; p < 128; p++) begin
                load(tag, s, p, lpn_of(s, p), p % 4);
            end
            for (int p = 0; p < 128; p++) begin
                lookup(tag, s, lpn_of(s, p), off_of(s, p), 1'b0, p, 1'b0);
            end
            lookup("R7", s, lpn_of(s, 127), (1 << (12 + s)) - 1, 1'b0, 127, 1'b0);
        end

        // permission matrix under 32 KB pages: page p holds level p%4
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 3; m++) begin
                for (int w = 0; w < 2; w++) begin
                    bit ok;
                    if (m == 0)      ok = 1'b1;
                    else if (m == 1) ok = (w == 0) || (p < 2);
                    else             ok = (p == 0) || (p == 1 && w == 0);
                    tag = (m == 0) ? "R9" : (m == 1) ? "R10" : "R11";
                    set_mode(m);
                    lookup(tag, 3, lpn_of(3, p), off_of(3, p), w[0], p, !ok);
                end
            end
        end
        @(negedge clk);
        cpu_sup = 1'b1;
        ctl_os_en = 1'b1;
        lookup("R9", 3, lpn_of(3, 3), 8, 1'b1, 3, 1'b0);

        // priority among duplicate logical pages (page 50 holds 831)
        set_mode(0);
        load("R8", 3, 70, 831, 0);
        lookup("R8", 3, 831, 44, 1'b0, 50, 1'b0);
        load("R8", 3, 20, 831, 0);
        lookup("R8", 3, 831, 44, 1'b0, 20, 1'b0);

        // refusals
        lookup("R12", 3, 6, 0, 1'b0, 0, 1'b1);
        set_mode(2);
        do_req("R12", 1'b1, enc_load(3, 5, 900, 0), 2, ab, pa);
        chk("R12", "user load abort", ab, 1);
        set_mode(1);
        do_req("R12", 1'b1, enc_load(3, 5, 900, 0), 2, ab, pa);
        chk("R12", "OS load abort", ab, 1);
        set_mode(0);
        lookup("R12", 3, lpn_of(3, 5), 100, 1'b0, 5, 1'b0);
        lookup("R12", 3, 900, 100, 1'b0, 0, 1'b1);
        do_req("R12", 1'b0, 26'h2000000, 2, ab, pa);
        chk("R12", "physical region read abort", ab, 1);
        do_req("R12", 1'b0, enc_load(3, 1, 1, 0), 2, ab, pa);
        chk("R12", "window read abort", ab, 1);

        // reset clears the table
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lookup("R1", 3, lpn_of(3, 5), 100, 1'b0, 0, 1'b1);

        finish_run();
    end

endmodule